// File: doc/BRIEF.md
# Keyed-Write Oscillator Control Register File

This block is the register file of a clock-source controller, reached over APB. Each control field takes effect only when software writes one of a small set of magic codes. Any other written value is stored as written, but it decodes to a defined safe setting. The design registers the raw written words. The control outputs are decoded from those stored words: oscillator enable, frequency-range select, eight 3-bit stage drive strengths, a dormant request, a divide ratio and the controls of the phase-shifted output. Every invalid write also raises a sticky bad-write flag, and software clears that flag by writing a one to it.

The oscillator, the analog behaviour and the interrupt logic lie outside this block. Three status conditions arrive as plain input signals and appear read-only in the status word: stable, divider running and enabled. A write takes effect on the clock edge that ends the APB access phase, so the decoded outputs change after that edge. Every transfer completes with no wait state and never reports an error.

Top module: `keyed_osc_regs`

## Requirements
- R1: After reset the outputs are: enable 1, range low (0), all drives 0, dormant 0, divide ratio 16 and phase enable 1 with flip 0 and shift 0. The readbacks are: control word 0x00FABAA0, dormant 0x77616B65, divider 0x0AB0 and phase 0x008. The bad-write flag is 0.
- R2: The 12-bit enable field sits in control bits 23:12. Code 0xD1E drives `osc_en_o` low. Every other code, including 0xFAB, drives it high.
- R3: The range field sits in control bits 11:0 and is Gray coded onto `range_o`: 0xFA4 gives 0 (low), 0xFA5 gives 1 (medium), 0xFA7 gives 2 (high) and 0xFA6 gives 3 (too-high). Any other code gives 0.
- R4: The drive registers sit at 0x04 (stages 0-3) and 0x08 (stages 4-7). Each holds a password in bits 31:16 and 3-bit stage fields at bits 2:0, 6:4, 10:8 and 14:12, lowest stage first. Stage n appears on `drive_o[3n+2:3n]` only while the stored password is 0x9696. Any other password drives all four stages of that register to 0. Readback is masked with 0xFFFF7777.
- R5: The dormant word at 0x0C sets `dormant_o` high only when it holds 0x636F6D61. Any other value, including 0x77616B65, selects wake (`dormant_o` low).
- R6: The divider word at 0x10 is valid only when its low 12 bits lie between 0xAA0 and 0xABF. The value d = word − 0xAA0 gives `div_o` = 32 for d = 0 and `div_o` = d otherwise. An invalid word gives 31.
- R7: The phase word at 0x14 holds a password in bits 11:4, enable at bit 3, flip at bit 2 and shift at bits 1:0. With password 0xAA the fields drive the outputs, except that flip reads 0 while `div_o` is 1. With any other password the outputs are enable 1, flip 0 and shift 0.
- R8: The status word at 0x18 carries a sticky flag at bit 24. The flag is set after any write of an invalid code: an enable or range code not listed in R2/R3, a drive password other than 0x9696, a dormant value other than the two codes, a divider word outside R6, or a phase password other than 0xAA. Writing status with bit 24 = 1 clears the flag. Writing status with bit 24 = 0 leaves it unchanged.
- R9: A status read returns `stable_i` at bit 31, the flag at bit 24, `div_running_i` at bit 16 and `enabled_i` at bit 12. All other bits read 0.
- R10: Reads and writes at any offset other than 0x00-0x18 in steps of 4 read 0 and change no state. `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W (8) | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| stable_i | input | 1 | Oscillator stable status |
| div_running_i | input | 1 | Post-divider running status |
| enabled_i | input | 1 | Oscillator enabled status |
| osc_en_o | output | 1 | Decoded oscillator enable |
| range_o | output | 2 | Decoded range: 0 low, 1 medium, 2 high, 3 too-high |
| drive_o | output | 24 | Stage drive strengths, stage n at bits 3n+2:3n |
| dormant_o | output | 1 | Dormant request |
| div_o | output | 6 | Divide ratio, 1 to 32 |
| phase_en_o | output | 1 | Phase-shifted output enable |
| phase_flip_o | output | 1 | Phase-shifted output inversion |
| phase_shift_o | output | 2 | Phase shift in input clocks |

## Verification
The hardest case to reach is the one where two stored words interact: a valid phase word with flip set, then a divider write that makes the ratio exactly 1. Flip must then drop without any further phase write. The bench writes the phase word first and the divider word second, then checks flip before and after.

The sticky flag is exercised with the rules applied in order. One invalid write sets it. A status write with bit 24 clear must leave it set, and only a write with bit 24 set clears it. Each invalid-code case starts from a cleared flag, so the bench can tell which write raised it.

// File: rtl/osc_key_pkg.sv
package osc_key_pkg;

    localparam int DATA_W         = 32;
    localparam int DS_W           = 3;
    localparam int STAGES_PER_REG = 4;
    localparam int NUM_DRV_REGS   = 2;
    localparam int NUM_STAGES     = STAGES_PER_REG * NUM_DRV_REGS;
    localparam int FIELD_PITCH    = 4;
    localparam int DIV_W          = 5;
    localparam int RATIO_W        = DIV_W + 1;
    localparam int NUM_REGS       = 7;

    // register slot indices; byte offset = index * 4
    localparam int IDX_CTRL  = 0;
    localparam int IDX_DRV0  = 1;
    localparam int IDX_DORM  = 3;
    localparam int IDX_DIV   = 4;
    localparam int IDX_PHASE = 5;
    localparam int IDX_STAT  = 6;

    localparam logic [11:0] EN_ON      = 12'hFAB;
    localparam logic [11:0] EN_OFF     = 12'hD1E;
    localparam logic [11:0] RNG_LOW    = 12'hFA4;
    localparam logic [11:0] RNG_MED    = 12'hFA5;
    localparam logic [11:0] RNG_HIGH   = 12'hFA7;
    localparam logic [11:0] RNG_TOOHI  = 12'hFA6;
    localparam logic [15:0] DRV_KEY    = 16'h9696;
    localparam logic [31:0] DRV_MASK   = 32'hFFFF_7777;
    localparam logic [31:0] SLEEP_KEY  = 32'h636F_6D61;
    localparam logic [31:0] WAKE_KEY   = 32'h7761_6B65;
    localparam logic [11:0] DIV_BASE   = 12'hAA0;
    localparam logic [7:0]  PH_KEY     = 8'hAA;

    localparam logic [23:0] CTRL_RST   = {EN_ON, 12'hAA0};
    localparam logic [11:0] DIV_RST    = 12'hAB0;
    localparam logic [11:0] PH_RST     = 12'h008;

    localparam int FLAG_BIT   = 24;
    localparam int STABLE_BIT = 31;
    localparam int RUN_BIT    = 16;
    localparam int ENA_BIT    = 12;

    typedef enum logic [1:0] {
        RANGE_LOW   = 2'd0,
        RANGE_MED   = 2'd1,
        RANGE_HIGH  = 2'd2,
        RANGE_TOOHI = 2'd3
    } range_e;

    typedef struct packed {
        logic   ok;
        range_e sel;
    } range_dec_t;

    typedef struct packed {
        logic               ok;
        logic [RATIO_W-1:0] ratio;
    } div_dec_t;

    typedef struct packed {
        logic       ok;
        logic       en;
        logic       flip;
        logic [1:0] shift;
    } phase_dec_t;

    function automatic logic en_code_ok(input logic [11:0] f);
        return (f == EN_ON) || (f == EN_OFF);
    endfunction

    function automatic range_dec_t range_decode(input logic [11:0] f);
        range_dec_t r;
        r.ok = 1'b1;
        case (f)
            RNG_LOW:   r.sel = RANGE_LOW;
            RNG_MED:   r.sel = RANGE_MED;
            RNG_HIGH:  r.sel = RANGE_HIGH;
            RNG_TOOHI: r.sel = RANGE_TOOHI;
            default: begin
                r.ok  = 1'b0;
                r.sel = RANGE_LOW;
            end
        endcase
        return r;
    endfunction

    function automatic div_dec_t div_decode(input logic [11:0] w);
        div_dec_t d;
        d.ok = (w[11:DIV_W] == DIV_BASE[11:DIV_W]);
        if (!d.ok)
            d.ratio = RATIO_W'(31);
        else if (w[DIV_W-1:0] == '0)
            d.ratio = RATIO_W'(32);
        else
            d.ratio = {1'b0, w[DIV_W-1:0]};
        return d;
    endfunction

    function automatic phase_dec_t phase_decode(input logic [11:0] w,
                                                input logic [RATIO_W-1:0] ratio);
        phase_dec_t p;
        p.ok = (w[11:4] == PH_KEY);
        if (p.ok) begin
            p.en    = w[3];
            p.flip  = w[2] && (ratio != RATIO_W'(1));
            p.shift = w[1:0];
        end else begin
            p.en    = 1'b1;
            p.flip  = 1'b0;
            p.shift = 2'd0;
        end
        return p;
    endfunction

endpackage

// File: rtl/osc_apb_decode.sv
module osc_apb_decode
    import osc_key_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output logic [NUM_REGS-1:0] hit_o,
    output logic [NUM_REGS-1:0] wr_o,
    output logic              rd_o
);
    logic wr_phase;
    assign wr_phase = psel && penable && pwrite;
    assign rd_o     = psel && !pwrite;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        assign hit_o[i] = (paddr == ADDR_W'(i * 4));
        assign wr_o[i]  = hit_o[i] && wr_phase;
    end

    // R10: at most one register is written per transfer
    a_r10_single_write: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_o));

endmodule

// File: rtl/osc_drive_reg.sv
module osc_drive_reg
    import osc_key_pkg::*;
#(
    parameter int STAGES = STAGES_PER_REG,
    parameter int W      = DS_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output logic [DATA_W-1:0]     raw_o,
    output logic [STAGES*W-1:0]   drive_o,
    output logic                  bad_o
);
    logic [DATA_W-1:0] raw_q;
    logic              key_ok;

    always_ff @(posedge clk) begin
        if (rst)
            raw_q <= '0;
        else if (we_i)
            raw_q <= wdata_i & DRV_MASK;
    end

    assign raw_o  = raw_q;
    assign key_ok = (raw_q[31:16] == DRV_KEY);
    assign bad_o  = we_i && (wdata_i[31:16] != DRV_KEY);

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        assign drive_o[s*W +: W] = key_ok ? raw_q[s*FIELD_PITCH +: W] : '0;
    end

    // R4: a write with a wrong password zeroes every stage of this register
    a_r4_key_gate: assert property (@(posedge clk) disable iff (rst)
        we_i && (wdata_i[31:16] != DRV_KEY) |=> drive_o == '0);

endmodule

// File: rtl/osc_sticky_flag.sv
module osc_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (set_i)
            flag_q <= 1'b1;
        else if (clr_i)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R8: an invalid write leaves the flag set
    a_r8_set_sticks: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);

    // R8: a clearing status write drops the flag
    a_r8_clear_drops: assert property (@(posedge clk) disable iff (rst)
        clr_i && !set_i |=> !flag_o);

    // R8: without a clear the flag never falls
    a_r8_no_self_clear: assert property (@(posedge clk) disable iff (rst)
        flag_o && !clr_i |=> flag_o);

endmodule

// File: rtl/keyed_osc_regs.sv
module keyed_osc_regs
    import osc_key_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       psel,
    input  logic                       penable,
    input  logic                       pwrite,
    input  logic [ADDR_W-1:0]          paddr,
    input  logic [DATA_W-1:0]          pwdata,
    output logic [DATA_W-1:0]          prdata,
    output logic                       pready,
    output logic                       pslverr,
    input  logic                       stable_i,
    input  logic                       div_running_i,
    input  logic                       enabled_i,
    output logic                       osc_en_o,
    output logic [1:0]                 range_o,
    output logic [NUM_STAGES*DS_W-1:0] drive_o,
    output logic                       dormant_o,
    output logic [RATIO_W-1:0]         div_o,
    output logic                       phase_en_o,
    output logic                       phase_flip_o,
    output logic [1:0]                 phase_shift_o
);
    localparam int DRV_OUT_W = STAGES_PER_REG * DS_W;

    logic [NUM_REGS-1:0] hit, wr;
    logic                rd;

    osc_apb_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .hit_o(hit), .wr_o(wr), .rd_o(rd)
    );

    // stored raw words
    logic [23:0] ctrl_q;
    logic [31:0] dorm_q;
    logic [11:0] div_q;
    logic [11:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= CTRL_RST;
            dorm_q  <= WAKE_KEY;
            div_q   <= DIV_RST;
            phase_q <= PH_RST;
        end else begin
            if (wr[IDX_CTRL])  ctrl_q  <= pwdata[23:0];
            if (wr[IDX_DORM])  dorm_q  <= pwdata;
            if (wr[IDX_DIV])   div_q   <= pwdata[11:0];
            if (wr[IDX_PHASE]) phase_q <= pwdata[11:0];
        end
    end

    // drive-strength registers
    logic [DATA_W-1:0]    drv_raw [NUM_DRV_REGS];
    logic [NUM_DRV_REGS-1:0] drv_bad;

    for (genvar g = 0; g < NUM_DRV_REGS; g++) begin : g_drv
        osc_drive_reg u_drv (
            .clk(clk), .rst(rst), .we_i(wr[IDX_DRV0 + g]), .wdata_i(pwdata),
            .raw_o(drv_raw[g]), .drive_o(drive_o[g*DRV_OUT_W +: DRV_OUT_W]),
            .bad_o(drv_bad[g])
        );
    end

    // decoded outputs
    range_dec_t rng_now;
    div_dec_t   div_now;
    phase_dec_t ph_now;

    assign rng_now       = range_decode(ctrl_q[11:0]);
    assign div_now       = div_decode(div_q);
    assign ph_now        = phase_decode(phase_q, div_now.ratio);
    assign osc_en_o      = (ctrl_q[23:12] != EN_OFF);
    assign range_o       = rng_now.sel;
    assign dormant_o     = (dorm_q == SLEEP_KEY);
    assign div_o         = div_now.ratio;
    assign phase_en_o    = ph_now.en;
    assign phase_flip_o  = ph_now.flip;
    assign phase_shift_o = ph_now.shift;

    // invalid-write detection on incoming data
    range_dec_t rng_in;
    div_dec_t   div_in;
    logic       bad_any, clr_flag, flag;

    assign rng_in  = range_decode(pwdata[11:0]);
    assign div_in  = div_decode(pwdata[11:0]);
    assign bad_any = (wr[IDX_CTRL] && !(en_code_ok(pwdata[23:12]) && rng_in.ok))
                  || (|drv_bad)
                  || (wr[IDX_DORM] && (pwdata != SLEEP_KEY) && (pwdata != WAKE_KEY))
                  || (wr[IDX_DIV] && !div_in.ok)
                  || (wr[IDX_PHASE] && (pwdata[11:4] != PH_KEY));
    assign clr_flag = wr[IDX_STAT] && pwdata[FLAG_BIT];

    osc_sticky_flag u_flag (
        .clk(clk), .rst(rst), .set_i(bad_any), .clr_i(clr_flag), .flag_o(flag)
    );

    // read mux
    logic [DATA_W-1:0] status_w;
    always_comb begin
        status_w             = '0;
        status_w[STABLE_BIT] = stable_i;
        status_w[FLAG_BIT]   = flag;
        status_w[RUN_BIT]    = div_running_i;
        status_w[ENA_BIT]    = enabled_i;
    end

    always_comb begin
        prdata = '0;
        if (rd) begin
            if (hit[IDX_CTRL])  prdata = {8'h00, ctrl_q};
            for (int g = 0; g < NUM_DRV_REGS; g++)
                if (hit[IDX_DRV0 + g]) prdata = drv_raw[g];
            if (hit[IDX_DORM])  prdata = dorm_q;
            if (hit[IDX_DIV])   prdata = {20'h0, div_q};
            if (hit[IDX_PHASE]) prdata = {20'h0, phase_q};
            if (hit[IDX_STAT])  prdata = status_w;
        end
    end

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    // R2: writing the disable code turns the oscillator off
    a_r2_disable: assert property (@(posedge clk) disable iff (rst)
        wr[IDX_CTRL] && (pwdata[23:12] == EN_OFF) |=> !osc_en_o);

    // R5: anything but the dormant code selects wake
    a_r5_wake_default: assert property (@(posedge clk) disable iff (rst)
        wr[IDX_DORM] && (pwdata != SLEEP_KEY) |=> !dormant_o);

    // R6: divide ratio always lies in 1..32
    a_r6_ratio_range: assert property (@(posedge clk) disable iff (rst)
        (div_o != '0) && (div_o <= RATIO_W'(32)));

    // R7: a wrong phase password yields enabled, unshifted, unflipped
    a_r7_phase_fallback: assert property (@(posedge clk) disable iff (rst)
        wr[IDX_PHASE] && (pwdata[11:4] != PH_KEY)
        |=> phase_en_o && !phase_flip_o && (phase_shift_o == 2'd0));

    // R10: writes to unmapped offsets leave the control word alone
    a_r10_unmapped_quiet: assert property (@(posedge clk) disable iff (rst)
        psel && penable && pwrite && (hit == '0) |=> $stable(ctrl_q));

endmodule

// File: tb/keyed_osc_regs_tb.sv
module keyed_osc_regs_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        psel, penable, pwrite;
    logic [7:0]  paddr;
    logic [31:0] pwdata, prdata;
    logic        pready, pslverr;
    logic        stable_i, div_running_i, enabled_i;
    logic        osc_en_o, dormant_o, phase_en_o, phase_flip_o;
    logic [1:0]  range_o, phase_shift_o;
    logic [23:0] drive_o;
    logic [5:0]  div_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    keyed_osc_regs u_dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .stable_i(stable_i), .div_running_i(div_running_i),
        .enabled_i(enabled_i), .osc_en_o(osc_en_o), .range_o(range_o),
        .drive_o(drive_o), .dormant_o(dormant_o), .div_o(div_o),
        .phase_en_o(phase_en_o), .phase_flip_o(phase_flip_o),
        .phase_shift_o(phase_shift_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic read_flag(output logic f);
        logic [31:0] s;
        apb_read(8'h18, s);
        f = s[24];
    endtask

    task automatic clear_flag();
        apb_write(8'h18, 32'h0100_0000);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        logic f;
        check("R1 osc_en", {31'b0, osc_en_o}, 1);
        check("R1 range", {30'b0, range_o}, 0);
        check("R1 drive", {8'b0, drive_o}, 0);
        check("R1 dormant", {31'b0, dormant_o}, 0);
        check("R1 div", {26'b0, div_o}, 16);
        check("R1 phase", {29'b0, phase_en_o, phase_flip_o, 1'b0} | {30'b0, phase_shift_o}, 32'h4);
        apb_read(8'h00, d); check("R1 ctrl read", d, 32'h00FA_BAA0);
        apb_read(8'h0C, d); check("R1 dormant read", d, 32'h7761_6B65);
        apb_read(8'h10, d); check("R1 div read", d, 32'h0000_0AB0);
        apb_read(8'h14, d); check("R1 phase read", d, 32'h0000_0008);
        read_flag(f);       check("R1 flag", {31'b0, f}, 0);
    endtask

    task automatic t_enable_range();
        logic [31:0] d;
        logic f;
        apb_write(8'h00, 32'h00D1_EFA7);
        check("R2 disable", {31'b0, osc_en_o}, 0);
        check("R3 high", {30'b0, range_o}, 2);
        apb_read(8'h00, d); check("R2 ctrl readback", d, 32'h00D1_EFA7);
        read_flag(f); check("R8 valid ctrl no flag", {31'b0, f}, 0);
        apb_write(8'h00, 32'h00FA_BFA6);
        check("R2 enable", {31'b0, osc_en_o}, 1);
        check("R3 toohigh", {30'b0, range_o}, 3);
        apb_write(8'h00, 32'h00FA_BFA5);
        check("R3 medium", {30'b0, range_o}, 1);
        apb_write(8'h00, 32'h00D1_EFA4);
        check("R3 low", {30'b0, range_o}, 0);
        apb_write(8'h00, 32'h0012_3FA5);
        check("R2 invalid code enables", {31'b0, osc_en_o}, 1);
        check("R3 medium kept", {30'b0, range_o}, 1);
        read_flag(f); check("R8 bad enable code", {31'b0, f}, 1);
        clear_flag();
        read_flag(f); check("R8 cleared", {31'b0, f}, 0);
        apb_write(8'h00, 32'h00FA_B000);
        check("R3 invalid range low", {30'b0, range_o}, 0);
        apb_write(8'h18, 32'h0000_0000);
        read_flag(f); check("R8 zero write keeps flag", {31'b0, f}, 1);
        clear_flag();
        read_flag(f); check("R8 cleared again", {31'b0, f}, 0);
    endtask

    task automatic t_drive();
        logic [31:0] d;
        logic f;
        apb_write(8'h04, 32'h9696_7531);
        apb_write(8'h08, 32'h9696_0246);
        check("R4 drive both", {8'b0, drive_o}, 32'h000A_6F59);
        read_flag(f); check("R8 good password no flag", {31'b0, f}, 0);
        apb_write(8'h04, 32'h9696_FFFF);
        apb_read(8'h04, d); check("R4 masked readback", d, 32'h9696_7777);
        check("R4 all seven", {8'b0, drive_o}, 32'h000A_6FFF);
        apb_write(8'h04, 32'h9695_7777);
        check("R4 bad password zeroes", {8'b0, drive_o}, 32'h000A_6000);
        read_flag(f); check("R8 bad password", {31'b0, f}, 1);
        clear_flag();
    endtask

    task automatic t_dormant();
        logic f;
        apb_write(8'h0C, 32'h636F_6D61);
        check("R5 dormant", {31'b0, dormant_o}, 1);
        apb_write(8'h0C, 32'h636F_6D60);
        check("R5 near miss wakes", {31'b0, dormant_o}, 0);
        read_flag(f); check("R8 bad dormant", {31'b0, f}, 1);
        clear_flag();
        apb_write(8'h0C, 32'h636F_6D61);
        apb_write(8'h0C, 32'h7761_6B65);
        check("R5 wake", {31'b0, dormant_o}, 0);
        read_flag(f); check("R8 wake no flag", {31'b0, f}, 0);
    endtask

    task automatic t_divider();
        logic f;
        apb_write(8'h10, 32'h0000_0AA0); check("R6 div 32", {26'b0, div_o}, 32);
        apb_write(8'h10, 32'h0000_0AA1); check("R6 div 1", {26'b0, div_o}, 1);
        apb_write(8'h10, 32'h0000_0ABF); check("R6 div 31", {26'b0, div_o}, 31);
        read_flag(f); check("R8 valid div no flag", {31'b0, f}, 0);
        apb_write(8'h10, 32'h0000_0AA7); check("R6 div 7", {26'b0, div_o}, 7);
        apb_write(8'h10, 32'h0000_0AC0); check("R6 invalid 31", {26'b0, div_o}, 31);
        read_flag(f); check("R8 bad divider", {31'b0, f}, 1);
        clear_flag();
    endtask

    task automatic t_phase();
        logic f;
        apb_write(8'h10, 32'h0000_0AA7);
        apb_write(8'h14, 32'h0000_0AA7);
        check("R7 en off", {31'b0, phase_en_o}, 0);
        check("R7 flip on", {31'b0, phase_flip_o}, 1);
        check("R7 shift 3", {30'b0, phase_shift_o}, 3);
        apb_write(8'h14, 32'h0000_0AAE);
        check("R7 en on", {31'b0, phase_en_o}, 1);
        check("R7 shift 2", {30'b0, phase_shift_o}, 2);
        check("R7 flip before div1", {31'b0, phase_flip_o}, 1);
        apb_write(8'h10, 32'h0000_0AA1);
        check("R7 flip ignored at div1", {31'b0, phase_flip_o}, 0);
        apb_write(8'h10, 32'h0000_0AA2);
        check("R7 flip back at div2", {31'b0, phase_flip_o}, 1);
        read_flag(f); check("R8 valid phase no flag", {31'b0, f}, 0);
        apb_write(8'h14, 32'h0000_0AB3);
        check("R7 fallback en", {31'b0, phase_en_o}, 1);
        check("R7 fallback flip", {31'b0, phase_flip_o}, 0);
        check("R7 fallback shift", {30'b0, phase_shift_o}, 0);
        read_flag(f); check("R8 bad phase", {31'b0, f}, 1);
        clear_flag();
    endtask

    task automatic t_status();
        logic [31:0] d;
        stable_i = 1'b1; enabled_i = 1'b1; div_running_i = 1'b0;
        apb_read(8'h18, d); check("R9 stable enabled", d, 32'h8000_1000);
        stable_i = 1'b0; enabled_i = 1'b0; div_running_i = 1'b1;
        apb_write(8'h0C, 32'h0000_0001);
        apb_read(8'h18, d); check("R9 running with flag", d, 32'h0101_0000);
        div_running_i = 1'b0;
        clear_flag();
        apb_read(8'h18, d); check("R9 all clear", d, 32'h0000_0000);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        logic f;
        apb_write(8'h00, 32'h00FA_BFA5);
        apb_write(8'h1C, 32'hFFFF_FFFF);
        apb_write(8'h02, 32'h00D1_EFA7);
        apb_read(8'h1C, d); check("R10 unmapped reads zero", d, 0);
        apb_read(8'h01, d); check("R10 misaligned reads zero", d, 0);
        apb_read(8'h00, d); check("R10 ctrl untouched", d, 32'h00FA_BFA5);
        check("R10 osc_en untouched", {31'b0, osc_en_o}, 1);
        read_flag(f); check("R10 no flag", {31'b0, f}, 0);
        check("R10 pready", {31'b0, pready}, 1);
        check("R10 pslverr", {31'b0, pslverr}, 0);
    endtask

    initial begin
        rst = 1'b1; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        paddr = '0; pwdata = '0;
        stable_i = 1'b0; div_running_i = 1'b0; enabled_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_enable_range();
        t_drive();
        t_dormant();
        t_divider();
        t_phase();
        t_status();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule